// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

This block lets two processors that share no bus pass a request and its answer. The requesting core (the master side) fills three 16-bit request words. Word 0 is the command code. For example, 0x0002 asks for a RAM read, and word 1 then names the address. The serving core (the slave side) reads those words, carries out the work, and returns the result in two 16-bit response words. The requesting core then collects them. The block does not interpret command codes.

Each core has its own simple port with a write strobe, a read strobe, an address and data. Write rights depend on the word: request words belong to the master side and response words to the slave side, while both sides may read everything. Two handshake flags drive level interrupts, one to each core:

- A pending flag tells the slave side that a command has arrived.
- A ready flag tells the master side that a response is waiting.

A sticky overrun bit reports a command that was replaced before it was served.

Top module: `mailbox_regs`

## Requirements
- R1: Reset (active-low `rst_n`) clears all five words to 0x0000, the three flags to 0 and both read-data outputs to 0x0000.
- R2: Request words sit at addresses 0, 1 and 2, and word 0 is the command. A master-side write stores its data at the clock edge. Both ports read these words back.
- R3: Response words sit at addresses 3 and 4, and word 3 is the first response. A slave-side write stores its data at the clock edge. Both ports read these words back.
- R4: Writes without the right have no effect: master writes to 3–4 and slave writes to 0–2 leave the words unchanged and do not touch any flag.
- R5: Addresses 5–7 read as 0x0000, and writes to them have no effect.
- R6: A master write to address 0 sets `req_pending` at the next edge, and `irq_slave` follows it. A slave write to address 3 clears it.
- R7: A slave write to address 3 sets `rsp_ready` at the next edge, and `irq_master` follows it. A master read of address 3 clears it.
- R8: Read data is registered.
  - It appears on the `*_rdata` output at the edge that samples the read strobe, and holds until the next read.
  - A read in the same cycle as a permitted write to the same word returns the old contents.
- R9: A master write to address 0 while `req_pending` is 1 replaces the command and sets `overrun`. A slave write to address 3 clears `overrun`.
- R10: When a set and a clear of the same flag arrive in one cycle, the set wins. This applies to `req_pending`, `rsp_ready` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_wr | input | 1 | Master-side write strobe |
| m_rd | input | 1 | Master-side read strobe |
| m_addr | input | 3 | Master-side word address |
| m_wdata | input | 16 | Master-side write data |
| m_rdata | output | 16 | Master-side registered read data |
| s_wr | input | 1 | Slave-side write strobe |
| s_rd | input | 1 | Slave-side read strobe |
| s_addr | input | 3 | Slave-side word address |
| s_wdata | input | 16 | Slave-side write data |
| s_rdata | output | 16 | Slave-side registered read data |
| req_pending | output | 1 | Command waiting for the slave side |
| rsp_ready | output | 1 | Response waiting for the master side |
| overrun | output | 1 | A pending command was replaced |
| irq_slave | output | 1 | Interrupt to the slave core |
| irq_master | output | 1 | Interrupt to the master core |

## Verification
Every result is due exactly one clock edge after its strobe: stored words, read data and all three flags. No flag has an extra delay stage. The bench drives strobes on the falling edge and drops them on the next falling edge. It samples outputs at that second falling edge, half a period after the edge that produced them. Collision and set-versus-clear cases are driven as single-cycle overlaps of both ports, so the old-value read and the flag priority are seen in that same sample.

// File: rtl/mailbox_regs.sv
module mailbox_regs #(
  parameter int DW   = 16,
  parameter int AW   = 3,
  parameter int NREQ = 3,
  parameter int NRSP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_wr,
  input  logic          m_rd,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] m_rdata,
  input  logic          s_wr,
  input  logic          s_rd,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] s_rdata,
  output logic          req_pending,
  output logic          rsp_ready,
  output logic          overrun,
  output logic          irq_slave,
  output logic          irq_master
);
  localparam int RSP_BASE = NREQ;

  logic [DW-1:0] req_q [NREQ];
  logic [DW-1:0] rsp_q [NRSP];

  wire cmd_wr  = m_wr && (m_addr == '0);
  wire rsp0_wr = s_wr && (s_addr == AW'(RSP_BASE));
  wire rsp0_rd = m_rd && (m_addr == AW'(RSP_BASE));

  function automatic logic [DW-1:0] pick(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < NREQ; i++)
      if (a == AW'(i)) v = req_q[i];
    for (int j = 0; j < NRSP; j++)
      if (a == AW'(RSP_BASE + j)) v = rsp_q[j];
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREQ; i++) req_q[i] <= '0;
    end else if (m_wr) begin
      for (int i = 0; i < NREQ; i++)
        if (m_addr == AW'(i)) req_q[i] <= m_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NRSP; j++) rsp_q[j] <= '0;
    end else if (s_wr) begin
      for (int j = 0; j < NRSP; j++)
        if (s_addr == AW'(RSP_BASE + j)) rsp_q[j] <= s_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_rdata <= '0;
      s_rdata <= '0;
    end else begin
      if (m_rd) m_rdata <= pick(m_addr);
      if (s_rd) s_rdata <= pick(s_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pending <= 1'b0;
      rsp_ready   <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      if (cmd_wr)       req_pending <= 1'b1;
      else if (rsp0_wr) req_pending <= 1'b0;

      if (cmd_wr && req_pending) overrun <= 1'b1;
      else if (rsp0_wr)          overrun <= 1'b0;

      if (rsp0_wr)      rsp_ready <= 1'b1;
      else if (rsp0_rd) rsp_ready <= 1'b0;
    end
  end

  assign irq_slave  = req_pending;
  assign irq_master = rsp_ready;
endmodule

module mailbox_regs_chk #(
  parameter int AW   = 3,
  parameter int NREQ = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_wr,
  input logic          m_rd,
  input logic [AW-1:0] m_addr,
  input logic          s_wr,
  input logic [AW-1:0] s_addr,
  input logic          req_pending,
  input logic          rsp_ready,
  input logic          overrun
);
  wire c_cmd = m_wr && (m_addr == '0);
  wire c_rw  = s_wr && (s_addr == AW'(NREQ));
  wire c_rr  = m_rd && (m_addr == AW'(NREQ));

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n) c_cmd |=> req_pending); // R6
  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n) c_rw && !c_cmd |=> !req_pending); // R6
  AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n) c_rw |=> rsp_ready); // R7
  AST_READY_CLR: assert property (@(posedge clk) disable iff (!rst_n) c_rr && !c_rw |=> !rsp_ready); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) c_cmd && req_pending |=> overrun); // R9
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(overrun) |-> $past(req_pending) && $past(c_cmd)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) c_cmd && c_rw |=> req_pending && rsp_ready); // R10
endmodule

bind mailbox_regs mailbox_regs_chk u_chk (.*);

// File: tb/mailbox_regs_test.sv
`timescale 1ns/1ps
module mailbox_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
  logic [2:0]  m_addr = '0, s_addr = '0;
  logic [15:0] m_wdata = '0, s_wdata = '0;
  logic [15:0] m_rdata, s_rdata;
  logic        req_pending, rsp_ready, overrun, irq_slave, irq_master;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mailbox_regs uut (.*);

  // {slave side, write, addr[2:0], wdata[15:0], expected read[15:0]}
  localparam logic [36:0] VEC [12] = '{
    {1'b0, 1'b1, 3'd0, 16'h0002, 16'h0000},
    {1'b0, 1'b1, 3'd1, 16'h1234, 16'h0000},
    {1'b0, 1'b1, 3'd2, 16'hBEEF, 16'h0000},
    {1'b1, 1'b0, 3'd0, 16'h0000, 16'h0002},
    {1'b1, 1'b0, 3'd1, 16'h0000, 16'h1234},
    {1'b1, 1'b0, 3'd2, 16'h0000, 16'hBEEF},
    {1'b1, 1'b1, 3'd3, 16'h00A5, 16'h0000},
    {1'b1, 1'b1, 3'd4, 16'h5A5A, 16'h0000},
    {1'b0, 1'b0, 3'd4, 16'h0000, 16'h5A5A},
    {1'b0, 1'b0, 3'd3, 16'h0000, 16'h00A5},
    {1'b0, 1'b0, 3'd0, 16'h0000, 16'h0002},
    {1'b1, 1'b0, 3'd4, 16'h0000, 16'h5A5A}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mwrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); m_wr = 1; m_addr = a; m_wdata = d;
    @(negedge clk); m_wr = 0;
  endtask

  task automatic swrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); s_wr = 1; s_addr = a; s_wdata = d;
    @(negedge clk); s_wr = 0;
  endtask

  task automatic mread(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); m_rd = 1; m_addr = a;
    @(negedge clk); m_rd = 0; d = m_rdata;
  endtask

  task automatic sread(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); s_rd = 1; s_addr = a;
    @(negedge clk); s_rd = 0; d = s_rdata;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 flags", {13'b0, req_pending, rsp_ready, overrun}, 16'h0000);
    chk("R1 m_rdata", m_rdata, 16'h0000);
    chk("R1 s_rdata", s_rdata, 16'h0000);
    for (int a = 0; a < 5; a++) begin
      mread(3'(a), r);
      chk("R1 word", r, 16'h0000);
    end

    // R2/R3 vector table
    for (int i = 0; i < 12; i++) begin
      logic [36:0] v;
      v = VEC[i];
      if (v[35]) begin
        if (v[36]) swrite(v[34:32], v[31:16]);
        else       mwrite(v[34:32], v[31:16]);
      end else begin
        if (v[36]) sread(v[34:32], r);
        else       mread(v[34:32], r);
        chk(v[34:32] < 3 ? "R2 request word" : "R3 response word", r, v[15:0]);
      end
    end
    chk("R6/R7 flags after exchange", {14'b0, req_pending, rsp_ready}, 16'h0000);

    // R4 writes without permission
    mwrite(3'd3, 16'hFFFF);
    sread(3'd3, r);
    chk("R4 master write to response", r, 16'h00A5);
    chk("R4 ready untouched", {15'b0, rsp_ready}, 16'h0000);
    swrite(3'd0, 16'h7777);
    mread(3'd0, r);
    chk("R4 slave write to command", r, 16'h0002);
    chk("R4 pending untouched", {15'b0, req_pending}, 16'h0000);

    // R5 unmapped
    mwrite(3'd6, 16'hAAAA);
    mread(3'd6, r);
    chk("R5 unmapped read", r, 16'h0000);
    sread(3'd5, r);
    chk("R5 unmapped slave read", r, 16'h0000);

    // R6 / R9 / R7 handshake
    mwrite(3'd0, 16'h0002);
    chk("R6 pending and irq", {14'b0, req_pending, irq_slave}, 16'h0003);
    chk("R9 no overrun", {15'b0, overrun}, 16'h0000);
    mwrite(3'd0, 16'h0003);
    chk("R9 overrun set", {15'b0, overrun}, 16'h0001);
    sread(3'd0, r);
    chk("R9 command replaced", r, 16'h0003);
    swrite(3'd3, 16'h2222);
    chk("R6 pending cleared", {14'b0, req_pending, irq_slave}, 16'h0000);
    chk("R9 overrun cleared", {15'b0, overrun}, 16'h0001 ^ 16'h0001);
    chk("R7 ready and irq", {14'b0, rsp_ready, irq_master}, 16'h0003);

    // R8 collision and R10 ready set wins
    @(negedge clk); m_rd = 1; m_addr = 3'd3; s_wr = 1; s_addr = 3'd3; s_wdata = 16'h1111;
    @(negedge clk); m_rd = 0; s_wr = 0;
    chk("R8 old value on collision", m_rdata, 16'h2222);
    chk("R10 ready set wins", {15'b0, rsp_ready}, 16'h0001);
    chk("R8 rdata holds without strobe", m_rdata, 16'h2222);
    mread(3'd3, r);
    chk("R8 new value", r, 16'h1111);
    chk("R7 ready cleared by read", {14'b0, rsp_ready, irq_master}, 16'h0000);

    // R10 pending set wins
    @(negedge clk); m_wr = 1; m_addr = 3'd0; m_wdata = 16'h0005; s_wr = 1; s_addr = 3'd3; s_wdata = 16'h3333;
    @(negedge clk);
    chk("R10 pending set wins", {14'b0, req_pending, overrun}, 16'h0002);
    @(negedge clk); m_wr = 0; s_wr = 0;
    chk("R10 overrun set wins", {14'b0, req_pending, overrun}, 16'h0003);
    swrite(3'd3, 16'h4444);
    chk("R9 served clears", {14'b0, req_pending, overrun}, 16'h0000);

    // R1 reset mid-run
    mwrite(3'd1, 16'h9999);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 flags after reset", {13'b0, req_pending, rsp_ready, overrun}, 16'h0000);
    sread(3'd1, r);
    chk("R1 request cleared", r, 16'h0000);
    mread(3'd4, r);
    chk("R1 response cleared", r, 16'h0000);

    done = 1;
    summary();
  end
endmodule